// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block collects event strobes from nine sources and keeps each one in a sticky status register. The sources are a watchdog time-out, an over-temperature event, a ground-shift event, a bad serial clock count, a battery drop, a regulator short, a CAN fault, a LIN fault and a wake-up. A host reads the register through a single-cycle read strobe. The read returns the current contents and clears them. An event that arrives in the same cycle as the read is kept. Two of the sources are pin inputs, and their events come from falling edges on those pins.

The block drives an active-low interrupt request to the host. Urgent events (battery drop, serial clock count failure, watchdog time-out) pull the request low at once. The deferred events are over-temperature, ground shift, regulator short, CAN, LIN and wake-up. When throttling is on, they may pull the request low only once per watchdog period. After every read the request is held high for a fixed number of cycles, so the next assertion always gives the host a clean falling edge. A per-source enable mask decides which latched bits may drive the request. Masked bits are still latched.

The interface is made of plain control and status pins. The read strobe has no back-pressure: the block accepts a read in any cycle. The read data is valid in the same cycle as the strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: A cycle with `rd_req` high clears the status register at the next clock edge, and reset also clears it. A status bit that is set stays set until one of these happens.
- R2: An event that arrives in the same cycle as `rd_req` is set in the status register after that edge.
- R3: After each read edge, `irq_n` stays high for exactly HOLD_CYC cycles. With the default of 16, the first cycle in which it may go low is after the 16th edge following the read edge.
- R4: The urgent bits are 11 (watchdog time-out), 8 (serial clock count failure) and 7 (battery drop). When one of them is set and enabled, `irq_n` goes low in the cycle right after the event edge unless the hold window is running. This holds whether or not throttling is on.
- R5: When `throttle_en` is 1, the deferred bits are 10, 9, 6, 5, 4 and 3. They can drive `irq_n` low only while a gate is open. The gate is open after reset and is reopened by `wd_tick`. It closes once a deferred assertion has fired, and that assertion appears one cycle after the status bit is set.
- R6: Status bit map in `rd_data`: 11 watchdog time-out, 10 over-temperature, 9 ground shift, 8 serial clock count failure, 7 battery drop, 6 regulator short, 5 CAN fault, 4 LIN fault, 3 wake-up. Bits 2..0 read as 0.
- R7: A falling edge on `sense_in` sets bit 7, and a falling edge on `wake_n_in` sets bit 3. A rising edge on either pin sets nothing.
- R8: A bit whose `irq_en` bit is 0 is still latched, but it does not drive `irq_n` low.
- R9: When `throttle_en` is 0, deferred bits drive `irq_n` low as soon as they are set, in the same way as urgent bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_wdt | input | 1 | Watchdog time-out event strobe |
| evt_otemp | input | 1 | Over-temperature event strobe |
| evt_gnd | input | 1 | Ground-shift event strobe |
| evt_spiclk | input | 1 | Serial clock count failure strobe |
| evt_rail | input | 1 | Regulator short-circuit strobe |
| evt_can | input | 1 | CAN fault-change strobe |
| evt_lin | input | 1 | LIN fault-change strobe |
| sense_in | input | 1 | Battery sense pin; a falling edge is an event |
| wake_n_in | input | 1 | Wake pin; a falling edge is an event |
| irq_en | input | 12 | Per-bit interrupt enable, using the R6 bit map |
| throttle_en | input | 1 | Turns on the once-per-period gate for deferred events |
| wd_tick | input | 1 | One-cycle watchdog period pulse that reopens the gate |
| rd_req | input | 1 | Read strobe; clears the status register at the edge |
| rd_data | output | 12 | Current status register |
| irq_n | output | 1 | Interrupt request to the host, active low |

## Verification
The checker checks these rules on every cycle:
- The request stays high for the whole window after a read.
- An enabled urgent bit pulls the request low once the window has ended.
- A request that is fully masked stays high.
- A read clears a bit unless a new event for that bit arrives in the same cycle.
- A strobe that coincides with a read survives the read.

Some behaviour is only shown by the bench scenarios:
- the exact bit map seen through the edge-detected pins;
- the once-per-period gating, including a deferred event that stays blocked until the next tick;
- the one-cycle delay before a deferred assertion.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W  = 12;
  localparam int B_WDT   = 11;
  localparam int B_OTEMP = 10;
  localparam int B_GND   = 9;
  localparam int B_SPI   = 8;
  localparam int B_BAT   = 7;
  localparam int B_RAIL  = 6;
  localparam int B_CAN   = 5;
  localparam int B_LIN   = 4;
  localparam int B_WAKE  = 3;

  localparam logic [STAT_W-1:0] URGENT_MASK =
    (STAT_W'(1) << B_WDT) | (STAT_W'(1) << B_SPI) | (STAT_W'(1) << B_BAT);
  localparam logic [STAT_W-1:0] DEFER_MASK =
    (STAT_W'(1) << B_OTEMP) | (STAT_W'(1) << B_GND) | (STAT_W'(1) << B_RAIL) |
    (STAT_W'(1) << B_CAN) | (STAT_W'(1) << B_LIN) | (STAT_W'(1) << B_WAKE);
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= pin[i];
    end
    assign fall[i] = prev_q & ~pin[i];
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/irq_defer_gate.sv
module irq_defer_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pending,
  input  logic hold_active,
  input  logic clear,
  output logic signal
);
  logic gate_q, sig_q, fire;

  assign fire = gate_q & pending & ~hold_active & ~sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b1;
      sig_q  <= 1'b0;
    end else begin
      if (tick)      gate_q <= 1'b1;
      else if (fire) gate_q <= 1'b0;
      if (clear)     sig_q <= 1'b0;
      else if (fire) sig_q <= 1'b1;
    end
  end

  assign signal = sig_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_wdt,
  input  logic              evt_otemp,
  input  logic              evt_gnd,
  input  logic              evt_spiclk,
  input  logic              evt_rail,
  input  logic              evt_can,
  input  logic              evt_lin,
  input  logic              sense_in,
  input  logic              wake_n_in,
  input  logic [STAT_W-1:0] irq_en,
  input  logic              throttle_en,
  input  logic              wd_tick,
  input  logic              rd_req,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_n
);
  logic [1:0]        pin_fall;
  logic [STAT_W-1:0] evt_vec, status_q;
  logic              hold_active, defer_sig, urgent_hit, defer_hit;

  irq_fall_detect #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .pin({sense_in, wake_n_in}),
    .fall(pin_fall)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_WDT]   = evt_wdt;
    evt_vec[B_OTEMP] = evt_otemp;
    evt_vec[B_GND]   = evt_gnd;
    evt_vec[B_SPI]   = evt_spiclk;
    evt_vec[B_BAT]   = pin_fall[1];
    evt_vec[B_RAIL]  = evt_rail;
    evt_vec[B_CAN]   = evt_can;
    evt_vec[B_LIN]   = evt_lin;
    evt_vec[B_WAKE]  = pin_fall[0];
  end

  // clear and set merged in one update so a same-cycle event survives the read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (rd_req ? '0 : status_q) | evt_vec;
  end

  irq_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(rd_req), .active(hold_active)
  );

  assign urgent_hit = |(status_q & irq_en & URGENT_MASK);
  assign defer_hit  = |(status_q & irq_en & DEFER_MASK);

  irq_defer_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .tick(wd_tick),
    .pending(defer_hit & throttle_en),
    .hold_active(hold_active),
    .clear(rd_req),
    .signal(defer_sig)
  );

  assign rd_data = status_q;
  assign irq_n   = ~(~hold_active &
                     (urgent_hit | (defer_hit & (~throttle_en | defer_sig))));
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int HOLD_CYC = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        evt_spiclk,
  input logic        evt_otemp,
  input logic [11:0] irq_en,
  input logic [11:0] rd_data,
  input logic        irq_n
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           win_q <= '0;
    else if (rd_req)      win_q <= CW'(HOLD_CYC);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> irq_n);

  assert_urgent_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == '0 && rd_data[8] && irq_en[8]) |-> !irq_n);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & irq_en) == 12'h000) |-> irq_n);

  assert_keep_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && evt_spiclk) |=> rd_data[8]);

  assert_read_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !evt_otemp) |=> !rd_data[10]);

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[10] && !rd_req) |=> rd_data[10]);
endmodule

bind irq_status_ctrl irq_status_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .evt_spiclk(evt_spiclk),
  .evt_otemp(evt_otemp), .irq_en(irq_en), .rd_data(rd_data), .irq_n(irq_n)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_wdt = 0, evt_otemp = 0, evt_gnd = 0, evt_spiclk = 0;
  logic evt_rail = 0, evt_can = 0, evt_lin = 0;
  logic sense_in = 1, wake_n_in = 1;
  logic [11:0] irq_en = 12'hFFF;
  logic throttle_en = 0, wd_tick = 0, rd_req = 0;
  logic [11:0] rd_data;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_ctrl #(.HOLD_CYC(16)) uut (
    .clk(clk), .rst_n(rst_n), .evt_wdt(evt_wdt), .evt_otemp(evt_otemp),
    .evt_gnd(evt_gnd), .evt_spiclk(evt_spiclk), .evt_rail(evt_rail),
    .evt_can(evt_can), .evt_lin(evt_lin), .sense_in(sense_in),
    .wake_n_in(wake_n_in), .irq_en(irq_en), .throttle_en(throttle_en),
    .wd_tick(wd_tick), .rd_req(rd_req), .rd_data(rd_data), .irq_n(irq_n)
  );

  // {events[11:0], read, expected rd_data[11:0], expected irq_n}
  localparam logic [25:0] VEC [9] = '{
    {12'h000, 1'b0, 12'h000, 1'b1},
    {12'h400, 1'b0, 12'h400, 1'b0},
    {12'h020, 1'b0, 12'h420, 1'b0},
    {12'h000, 1'b1, 12'h000, 1'b1},
    {12'h100, 1'b1, 12'h100, 1'b1},
    {12'h080, 1'b0, 12'h180, 1'b1},
    {12'h008, 1'b0, 12'h188, 1'b1},
    {12'hA50, 1'b0, 12'hBD8, 1'b1},
    {12'h000, 1'b1, 12'h000, 1'b1}
  };

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_evt(logic [11:0] e);
    evt_wdt = e[11]; evt_otemp = e[10]; evt_gnd = e[9]; evt_spiclk = e[8];
    sense_in = ~e[7]; evt_rail = e[6]; evt_can = e[5]; evt_lin = e[4];
    wake_n_in = ~e[3];
  endtask

  task automatic do_read();
    rd_req = 1; step(); rd_req = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1 reset rd_data", rd_data, 12'h000);
    check("R1 reset irq_n", {11'd0, irq_n}, 12'h001);
    rst_n = 1;
    step();

    // R6 R7 R2 R1 R9 R3: table walk, throttle off
    for (int i = 0; i < 9; i++) begin
      drive_evt(VEC[i][25:14]);
      rd_req = VEC[i][13];
      step();
      check($sformatf("R6/R7/R2/R9 vec%0d data", i), rd_data, VEC[i][12:1]);
      check($sformatf("R3/R9 vec%0d irq", i), {11'd0, irq_n}, {11'd0, VEC[i][0]});
    end
    drive_evt(12'h000); rd_req = 0;
    step();
    check("R7 rising edge sets nothing", rd_data, 12'h000);

    // R3: hold window length after a read
    repeat (20) step();
    rd_req = 1; step(); rd_req = 0;
    evt_spiclk = 1; step(); evt_spiclk = 0;
    repeat (14) step();
    check("R3 still high at 15th edge", {11'd0, irq_n}, 12'h001);
    step();
    check("R3 low at 16th edge", {11'd0, irq_n}, 12'h000);
    check("R4 spi bit kept", rd_data, 12'h100);

    // R8: masked bit latched but quiet
    do_read();
    repeat (17) step();
    irq_en = 12'hFFF & ~12'h100;
    evt_spiclk = 1; step(); evt_spiclk = 0;
    check("R8 masked bit latched", rd_data, 12'h100);
    check("R8 masked irq high", {11'd0, irq_n}, 12'h001);
    irq_en = 12'hFFF;
    #1;
    check("R4 unmasked urgent low", {11'd0, irq_n}, 12'h000);

    // R5: throttled deferred events
    do_read();
    throttle_en = 1;
    repeat (17) step();
    evt_can = 1; step(); evt_can = 0;
    check("R5 deferred not yet", {11'd0, irq_n}, 12'h001);
    step();
    check("R5 first deferred fires", {11'd0, irq_n}, 12'h000);
    do_read();
    repeat (17) step();
    evt_lin = 1; step(); evt_lin = 0;
    repeat (3) step();
    check("R5 gate closed irq high", {11'd0, irq_n}, 12'h001);
    check("R5 lin latched", rd_data, 12'h010);
    wd_tick = 1; step(); wd_tick = 0;
    step();
    check("R5 tick reopens gate", {11'd0, irq_n}, 12'h000);

    // R4: urgent while gate closed
    do_read();
    repeat (17) step();
    evt_wdt = 1; step(); evt_wdt = 0;
    check("R4 urgent under throttle", {11'd0, irq_n}, 12'h000);
    check("R4 wdt bit", rd_data, 12'h800);

    // R1: reset clears
    rst_n = 0; #2;
    check("R1 reset clears", rd_data, 12'h000);
    check("R1 reset irq high", {11'd0, irq_n}, 12'h001);
    rst_n = 1;
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule